// File: doc/BRIEF.md
# Eight-Bit Timer with Two Compare Channels

This block is an 8-bit up-counter with two compare channels, an overflow source and an interrupt front end. The counter advances once per timer tick. A tick is one cycle of a one-cycle enable pulse, taken from a set of prescaler taps that a clock-select field picks. The divider chain that makes the taps lives outside this block.

On every tick the current count is compared against two compare registers. A hit sets that channel's flag and can toggle its wave output. A tick at the top count wraps the counter to zero and sets the overflow flag. An interrupt request leaves the block only when the flag, its mask bit and the global enable input are all high. Software clears a flag by writing a one to it, and the interrupt controller clears it with an acknowledge pulse. When software loads the counter, compare matching is held off until the first tick after the load has passed, so a freshly loaded value equal to a compare value does not fire.

All state sits behind a small register bus. A write takes effect at the clock edge on which `bus_sel` and `bus_we` are both high. Read data is combinational from `bus_addr`. The bus is always ready and has no back-pressure.

Top module: `tmr8_dual_cmp`

## Requirements
- R1: After reset every register reads zero, `irq_req` is 0 and `wave` is 0.
- R2: The counter (address 1) increments by one on each tick and is readable. A bus write loads it, and a load takes priority over a tick in the same cycle.
- R3: Clock-select code 0 (control bits 2:0) produces no ticks. Code k from 1 to 7 uses `tap_pulse[k-1]`, whose taps divide by 1, 8, 32, 64, 128, 256 and 1024.
- R4: A tick on which the count equals compare A (address 2) sets flag bit 1. A tick on which it equals compare B (address 3) sets flag bit 2. The flags are at address 5.
- R5: The first tick after a counter load produces no compare match, and neither does a tick in the same cycle as a load.
- R6: A tick at count 255 wraps the counter to 0 and sets flag bit 0 (overflow).
- R7: `irq_req[i]` is high exactly when flag bit i, mask bit i (address 4; bit 2 is B, bit 1 is A, bit 0 is overflow) and `gie` are all high. Mask bits 7:3 read as zero.
- R8: Writing a one to a flag bit clears it, and writing a zero leaves it unchanged. A one-cycle `irq_ack[i]` pulse clears flag i.
- R9: A compare match toggles `wave[0]` (channel A) when control bit 3 is set, and toggles `wave[1]` (channel B) when control bit 4 is set. Otherwise the pin holds its value.
- R10: Register map: 0 is control, 1 is counter, 2 is compare A, 3 is compare B, 4 is mask, 5 is flags. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_pulse | input | 7 | One-cycle enables from the prescaler taps |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 3 | Acknowledge pulses, same bit layout as flags |
| irq_req | output | 3 | Interrupt requests, same bit layout as flags |
| wave | output | 2 | Compare toggle outputs, bit 0 is A and bit 1 is B |

## Verification
The counter runs under every clock-select code over windows of exactly two tap periods, which separates each division ratio and the stopped code. Compare runs use distinct A and B values with only one toggle enable set, so a swapped channel, a missing flag or an ungated toggle each shows up. The load-blocking case starts once from a value equal to compare A and once from one below it: the first run must stay silent and the second must fire. Wrap, write-one-clear, write-zero, acknowledge and the three-way interrupt gate are each exercised one input at a time.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  localparam int unsigned TCD_CS_W     = 3;
  localparam int unsigned TCD_NUM_TAPS = 7;
  localparam int unsigned TCD_SRC_OVF  = 0;

  localparam int unsigned TCD_A_CTRL = 0;
  localparam int unsigned TCD_A_CNT  = 1;
  localparam int unsigned TCD_A_CMP0 = 2;

  function automatic int unsigned tcd_a_mask(input int unsigned nch);
    return TCD_A_CMP0 + nch;
  endfunction

  function automatic int unsigned tcd_a_flag(input int unsigned nch);
    return TCD_A_CMP0 + nch + 1;
  endfunction
endpackage

// File: rtl/tcd_tick_sel.sv
module tcd_tick_sel #(
  parameter int unsigned CS_W     = 3,
  parameter int unsigned NUM_TAPS = 7
) (
  input  logic [CS_W-1:0]     sel,
  input  logic [NUM_TAPS-1:0] tap_pulse,
  output logic                tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (sel == CS_W'(i + 1)) tick = tap_pulse[i];
    end
  end
endmodule

// File: rtl/tcd_counter.sv
module tcd_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap,
  output logic         block
);
  logic [W-1:0] cnt_q;
  logic         blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      blk_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
      blk_q <= 1'b0;
    end
  end

  assign count = cnt_q;
  assign block = blk_q;
  assign wrap  = tick && !load && (cnt_q == '1);
endmodule

// File: rtl/tcd_cmp_chan.sv
module tcd_cmp_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] count,
  input  logic         tick,
  input  logic         block,
  input  logic         load,
  input  logic         wave_en,
  output logic [W-1:0] cmp_val,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] cmp_q;
  logic         wave_q;

  assign match = tick && !block && !load && (count == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr_en) cmp_q <= wr_data;
      if (match && wave_en) wave_q <= !wave_q;
    end
  end

  assign cmp_val = cmp_q;
  assign wave    = wave_q;
endmodule

// File: rtl/tcd_irq_ctl.sv
module tcd_irq_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c_data,
  input  logic [N-1:0] ack,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         gie,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic [N-1:0] irq
);
  logic [N-1:0] flag_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr;

  assign clr = (w1c_en ? w1c_data : '0) | ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr) | set;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign irq   = gie ? (flag_q & mask_q) : '0;
endmodule

// File: rtl/tmr8_dual_cmp.sv
module tmr8_dual_cmp
  import tcd_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TCD_NUM_TAPS-1:0] tap_pulse,
  input  logic                   bus_sel,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [CNT_W-1:0]       bus_wdata,
  output logic [CNT_W-1:0]       bus_rdata,
  input  logic                   gie,
  input  logic [NUM_CH:0]        irq_ack,
  output logic [NUM_CH:0]        irq_req,
  output logic [NUM_CH-1:0]      wave
);
  localparam int unsigned NSRC   = NUM_CH + 1;
  localparam int unsigned CTRL_W = TCD_CS_W + NUM_CH;
  localparam int unsigned A_MASK = tcd_a_mask(NUM_CH);
  localparam int unsigned A_FLAG = tcd_a_flag(NUM_CH);

  logic                wr;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [TCD_CS_W-1:0] cs;
  logic [NUM_CH-1:0]   wave_en;
  logic                tick;
  logic                cnt_load;
  logic [CNT_W-1:0]    count_q;
  logic                wrap;
  logic                cnt_block;
  logic [NUM_CH-1:0]   match;
  logic [CNT_W-1:0]    cmp_val [NUM_CH];
  logic [NSRC-1:0]     flags;
  logic [NSRC-1:0]     mask;

  assign wr       = bus_sel && bus_we;
  assign cnt_load = wr && (bus_addr == ADDR_W'(TCD_A_CNT));
  assign cs       = ctrl_q[TCD_CS_W-1:0];
  assign wave_en  = ctrl_q[CTRL_W-1:TCD_CS_W];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr && bus_addr == ADDR_W'(TCD_A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  tcd_tick_sel #(.CS_W(TCD_CS_W), .NUM_TAPS(TCD_NUM_TAPS)) u_tick (
    .sel(cs), .tap_pulse(tap_pulse), .tick(tick)
  );

  tcd_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .load_val(bus_wdata), .count(count_q), .wrap(wrap), .block(cnt_block)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tcd_cmp_chan #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr && bus_addr == ADDR_W'(TCD_A_CMP0 + c)),
      .wr_data(bus_wdata), .count(count_q), .tick(tick),
      .block(cnt_block), .load(cnt_load), .wave_en(wave_en[c]),
      .cmp_val(cmp_val[c]), .match(match[c]), .wave(wave[c])
    );
  end

  tcd_irq_ctl #(.N(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set({match, wrap}),
    .w1c_en(wr && bus_addr == ADDR_W'(A_FLAG)),
    .w1c_data(bus_wdata[NSRC-1:0]),
    .ack(irq_ack),
    .mask_we(wr && bus_addr == ADDR_W'(A_MASK)),
    .mask_wdata(bus_wdata[NSRC-1:0]),
    .gie(gie), .flags(flags), .mask(mask), .irq(irq_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(TCD_A_CTRL)) bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(TCD_A_CNT))  bus_rdata = count_q;
    if (bus_addr == ADDR_W'(A_MASK))     bus_rdata = CNT_W'(mask);
    if (bus_addr == ADDR_W'(A_FLAG))     bus_rdata = CNT_W'(flags);
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(TCD_A_CMP0 + c)) bus_rdata = cmp_val[c];
    end
  end
endmodule

// File: rtl/tmr8_dual_cmp_chk.sv
module tmr8_dual_cmp_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CS_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              cnt_load,
  input logic              cnt_block,
  input logic [CS_W-1:0]   cs,
  input logic [CNT_W-1:0]  count_q,
  input logic [NUM_CH:0]   flags,
  input logic              gie,
  input logic [NUM_CH:0]   irq_req,
  input logic [NUM_CH-1:0] wave
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load) |=> $stable(count_q));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load) |=> (count_q == $past(count_q) + 1'b1));

  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == '0) |-> !tick);

  a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_block || cnt_load) |=> (((flags & ~$past(flags)) >> 1) == '0));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_load && count_q == '1) |=> (count_q == '0 && flags[0]));

  a_r7_gie_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0));

  a_r9_wave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave));
endmodule

bind tmr8_dual_cmp tmr8_dual_cmp_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .CS_W(tcd_pkg::TCD_CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_load(cnt_load),
  .cnt_block(cnt_block), .cs(cs), .count_q(count_q), .flags(flags),
  .gie(gie), .irq_req(irq_req), .wave(wave)
);

// File: tb/tmr8_dual_cmp_test.sv
`timescale 1ns/1ps
module tmr8_dual_cmp_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] tap_pulse = '0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       gie = 1'b0;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq_req;
  logic [1:0] wave;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam int DIVS [7] = '{1, 8, 32, 64, 128, 256, 1024};

  tmr8_dual_cmp uut (
    .clk(clk), .rst_n(rst_n), .tap_pulse(tap_pulse), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .wave(wave)
  );

  always #10 clk = ~clk;

  initial begin : taps
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int k = 0; k < 7; k++) tap_pulse[k] = ((cyc % DIVS[k]) == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 3'(a);
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R1 reg after reset", v, 0);
    end
    check("R1 irq_req", int'(irq_req), 0);
    check("R1 wave", int'(wave), 0);
  endtask

  task automatic t_count_and_stop;
    int v, v2;
    wr(1, 10);
    wr(0, 1);
    rd(1, v);
    check("R2 loaded count", v, 10);
    repeat (5) @(negedge clk);
    rd(1, v);
    check("R2 counts by one per tick", v, 15);
    wr(1, 100);
    rd(1, v);
    check("R2 load wins over tick", v, 100);
    wr(0, 0);
    rd(1, v);
    repeat (20) @(negedge clk);
    rd(1, v2);
    check("R3 code 0 stops", v2, v);
  endtask

  task automatic t_prescale;
    int v0, v1;
    for (int k = 2; k <= 7; k++) begin
      wr(0, 0);
      wr(1, 0);
      wr(0, k);
      rd(1, v0);
      repeat (2 * DIVS[k-1]) @(negedge clk);
      rd(1, v1);
      check($sformatf("R3 code %0d two periods", k), v1 - v0, 2);
    end
    wr(0, 0);
  endtask

  task automatic t_compare;
    int v;
    wr(5, 7);
    wr(1, 0);
    wr(2, 5);
    wr(3, 7);
    wr(0, 8'h09);
    repeat (10) @(negedge clk);
    rd(5, v);
    check("R4 flags A and B set", v, 6);
    check("R9 wave A toggled, B held", int'(wave), 1);
    wr(0, 8'h08);
    rd(2, v);
    check("R10 compare A read", v, 5);
    rd(3, v);
    check("R10 compare B read", v, 7);
  endtask

  task automatic t_irq_and_clear;
    int v;
    gie = 1'b0;
    #1;
    check("R7 mask clear", int'(irq_req), 0);
    wr(4, 8'h02);
    check("R7 gie low", int'(irq_req), 0);
    @(negedge clk); gie = 1'b1; #1;
    check("R7 A request", int'(irq_req), 2);
    wr(4, 8'h06);
    check("R7 A and B requests", int'(irq_req), 6);
    wr(5, 8'h02);
    rd(5, v);
    check("R8 write one clears A", v, 4);
    wr(5, 8'h00);
    rd(5, v);
    check("R8 write zero no effect", v, 4);
    @(negedge clk); irq_ack = 3'b100;
    @(negedge clk); irq_ack = 3'b000; #1;
    rd(5, v);
    check("R8 ack clears B", v, 0);
    check("R8 no request left", int'(irq_req), 0);
    wr(4, 8'hFF);
    rd(4, v);
    check("R7 mask upper bits read zero", v, 7);
    gie = 1'b0;
  endtask

  task automatic t_overflow;
    int v;
    wr(1, 253);
    wr(0, 1);
    repeat (5) @(negedge clk);
    rd(1, v);
    check("R6 wrapped count", v, 2);
    rd(5, v);
    check("R6 overflow flag", v, 1);
    gie = 1'b1; #1;
    check("R7 overflow request", int'(irq_req), 1);
    gie = 1'b0;
    wr(0, 0);
    wr(5, 7);
  endtask

  task automatic t_block;
    int v;
    wr(2, 9);
    wr(1, 9);
    wr(0, 8'h09);
    repeat (3) @(negedge clk);
    rd(5, v);
    check("R5 load equal to compare blocked", v, 0);
    rd(1, v);
    check("R5 count still advanced", v, 12);
    check("R9 wave unchanged when blocked", int'(wave), 1);
    wr(0, 8'h08);
    wr(1, 8);
    wr(0, 8'h09);
    repeat (3) @(negedge clk);
    rd(5, v);
    check("R5 match after blocked tick", v, 2);
    check("R9 second toggle", int'(wave), 0);
    wr(0, 0);
    rd(6, v);
    check("R10 unmapped reads zero", v, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_and_stop();
    t_prescale();
    t_compare();
    t_irq_and_clear();
    t_overflow();
    t_block();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule